// File: doc/BRIEF.md
# Word Reorder, Extend and Bit-Field Unit

This block is a single-cycle data-path slice for an integer execution pipe. It gathers the operations that rearrange or trim the bits of one 32-bit operand: reversing the byte order of the whole word, swapping the bytes inside each halfword, swapping the bytes of the low halfword and then sign-extending it, mirroring the whole bit order, sign or zero extension of a byte or a halfword, and four bit-field operations. The bit-field operations are clear, insert, signed extract and unsigned extract.

The issuing stage presents an operation code, a source operand, a destination operand (read by clear and insert, and returned on a range error), and a field described by its lowest bit position and its length. The result is computed combinationally and captured in an output register. The output therefore appears one clock after the request, and it holds its value until the next request is accepted. A bit-field request whose field runs past bit 31 raises an error flag and passes the destination through unchanged.

Top module: `perm_field_unit`

## Requirements
- R1: `valid_o` equals the value `valid_i` had at the previous rising clock edge. `result_o` and `err_o` reflect the request that was accepted at that edge.
- R2: While `valid_i` is low, `result_o` and `err_o` keep their values across clock edges.
- R3: Op code 0 reverses the byte order of `src_i` (byte k moves to byte 3-k) and leaves the bits inside each byte unchanged.
- R4: Op code 1 swaps the two bytes within each 16-bit half of `src_i`, treating each half on its own.
- R5: Op code 2 swaps the two bytes of the low half of `src_i` and then fills bits 31:16 with copies of the resulting bit 15, which is source bit 7.
- R6: Op code 3 moves source bit i to result bit 31-i.
- R7: Op codes 4 and 5 sign-extend the low byte (copies of bit 7) and the low halfword (copies of bit 15). Op codes 6 and 7 zero-extend the low byte and the low halfword.
- R8: Op code 8 returns `dst_i` with bits lsb to lsb+len-1 cleared. A length of 0 leaves `dst_i` unchanged.
- R9: Op code 9 returns `dst_i` with bits lsb to lsb+len-1 replaced by the low len bits of `src_i`. All other bits of `dst_i` pass through unchanged.
- R10: Op codes 10 and 11 return bits lsb to lsb+len-1 of `src_i` right-aligned at bit 0. Op code 10 fills the upper bits with copies of the field's top bit, and op code 11 fills them with zeros. A length of 0 yields 0.
- R11: For op codes 8 to 11, lsb+len greater than 32 sets `err_o` and returns `dst_i` unchanged. Every other op code leaves `err_o` low.
- R12: While `rst_ni` is low, `valid_o`, `result_o` and `err_o` are all 0.
- R13: Op codes 12 to 15 are undefined. They return 0 and leave `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand for clear and insert |
| lsb_i | input | 5 | Lowest bit position of the field |
| len_i | input | 6 | Field length, 0 to 32 (larger values are range errors) |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 32 | Registered result |
| err_o | output | 1 | Field range error for the accepted request |

## Verification
The block keeps no state beyond its output register. A wrong mask, a wrong byte lane or a wrong range decision therefore shows up on `result_o` or `err_o` exactly one clock after the request that exposes it, and it never appears later than that. A stale or wrongly enabled output register shows up as a result that changes during idle cycles or fails to change on a new request. The bench compares all three outputs against a behavioural model on every clock. Directed cases place fields at both word edges, use full-width and empty fields, and use lengths that overrun the word. Random requests cover the remaining code space.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [3:0] {
    OP_REV_W   = 4'd0,
    OP_REV_H   = 4'd1,
    OP_REV_SH  = 4'd2,
    OP_BIT_REV = 4'd3,
    OP_SXT_B   = 4'd4,
    OP_SXT_H   = 4'd5,
    OP_UXT_B   = 4'd6,
    OP_UXT_H   = 4'd7,
    OP_BF_CLR  = 4'd8,
    OP_BF_INS  = 4'd9,
    OP_BF_SX   = 4'd10,
    OP_BF_UX   = 4'd11
  } op_e;

  function automatic logic is_field_op(logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/perm_reorder.sv
module perm_reorder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] rev_w_o,
  output logic [DATA_W-1:0] rev_h_o,
  output logic [DATA_W-1:0] rev_sh_o,
  output logic [DATA_W-1:0] rev_b_o
);
  localparam int BYTE_N = DATA_W / 8;
  localparam int HALF_N = DATA_W / 16;

  for (genvar b = 0; b < BYTE_N; b++) begin : g_byte
    assign rev_w_o[8*b +: 8] = src_i[8*(BYTE_N-1-b) +: 8];
  end

  for (genvar h = 0; h < HALF_N; h++) begin : g_half
    assign rev_h_o[16*h     +: 8] = src_i[16*h + 8 +: 8];
    assign rev_h_o[16*h + 8 +: 8] = src_i[16*h     +: 8];
  end

  // low half swapped, bit 15 of the swapped half is source bit 7
  assign rev_sh_o = {{(DATA_W-16){src_i[7]}}, src_i[7:0], src_i[15:8]};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign rev_b_o[i] = src_i[DATA_W-1-i];
  end
endmodule

// File: rtl/perm_extend.sv
module perm_extend #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] sxt_b_o,
  output logic [DATA_W-1:0] sxt_h_o,
  output logic [DATA_W-1:0] uxt_b_o,
  output logic [DATA_W-1:0] uxt_h_o
);
  localparam int UP_B = DATA_W - 8;
  localparam int UP_H = DATA_W - 16;

  assign sxt_b_o = {{UP_B{src_i[7]}},  src_i[7:0]};
  assign sxt_h_o = {{UP_H{src_i[15]}}, src_i[15:0]};
  assign uxt_b_o = {{UP_B{1'b0}},      src_i[7:0]};
  assign uxt_h_o = {{UP_H{1'b0}},      src_i[15:0]};
endmodule

// File: rtl/perm_bitfield.sv
module perm_bitfield #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [POS_W-1:0]  lsb_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] ins_o,
  output logic [DATA_W-1:0] sx_o,
  output logic [DATA_W-1:0] ux_o,
  output logic              range_err_o
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0]  lsb_ext, end_pos;
  logic [DATA_W-1:0] len_mask, fld_mask, shifted;
  logic [POS_W-1:0]  top_idx;
  logic              sign_bit;

  assign lsb_ext     = SUM_W'(lsb_i);
  assign end_pos     = lsb_ext + SUM_W'(len_i);
  assign range_err_o = end_pos > SUM_W'(DATA_W);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
    assign len_mask[i] = IDX < SUM_W'(len_i);
    assign fld_mask[i] = (IDX >= lsb_ext) && (IDX < end_pos);
  end

  // wraps to DATA_W-1 for a full-width field at bit 0
  assign top_idx  = lsb_i + len_i[POS_W-1:0] - POS_W'(1);
  assign sign_bit = (len_i != '0) && src_i[top_idx];
  assign shifted  = src_i >> lsb_i;

  assign clr_o = dst_i & ~fld_mask;
  assign ins_o = clr_o | ((src_i << lsb_i) & fld_mask);
  assign ux_o  = shifted & len_mask;
  assign sx_o  = ux_o | ({DATA_W{sign_bit}} & ~len_mask);
endmodule

// File: rtl/perm_field_unit.sv
module perm_field_unit
  import perm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [POS_W-1:0]  lsb_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  logic [DATA_W-1:0] rev_w, rev_h, rev_sh, rev_b;
  logic [DATA_W-1:0] sxt_b, sxt_h, uxt_b, uxt_h;
  logic [DATA_W-1:0] bf_clr, bf_ins, bf_sx, bf_ux;
  logic              range_err;
  logic [DATA_W-1:0] res_d;
  logic              err_d;

  perm_reorder #(.DATA_W(DATA_W)) u_reorder (
    .src_i   (src_i),
    .rev_w_o (rev_w),
    .rev_h_o (rev_h),
    .rev_sh_o(rev_sh),
    .rev_b_o (rev_b)
  );

  perm_extend #(.DATA_W(DATA_W)) u_extend (
    .src_i  (src_i),
    .sxt_b_o(sxt_b),
    .sxt_h_o(sxt_h),
    .uxt_b_o(uxt_b),
    .uxt_h_o(uxt_h)
  );

  perm_bitfield #(.DATA_W(DATA_W)) u_bitfield (
    .src_i      (src_i),
    .dst_i      (dst_i),
    .lsb_i      (lsb_i),
    .len_i      (len_i),
    .clr_o      (bf_clr),
    .ins_o      (bf_ins),
    .sx_o       (bf_sx),
    .ux_o       (bf_ux),
    .range_err_o(range_err)
  );

  always_comb begin
    err_d = is_field_op(op_i) && range_err;
    unique case (op_i)
      OP_REV_W:   res_d = rev_w;
      OP_REV_H:   res_d = rev_h;
      OP_REV_SH:  res_d = rev_sh;
      OP_BIT_REV: res_d = rev_b;
      OP_SXT_B:   res_d = sxt_b;
      OP_SXT_H:   res_d = sxt_h;
      OP_UXT_B:   res_d = uxt_b;
      OP_UXT_H:   res_d = uxt_h;
      OP_BF_CLR:  res_d = bf_clr;
      OP_BF_INS:  res_d = bf_ins;
      OP_BF_SX:   res_d = bf_sx;
      OP_BF_UX:   res_d = bf_ux;
      default:    res_d = '0;
    endcase
    if (err_d) res_d = dst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        err_o    <= err_d;
      end
    end
  end
endmodule

// File: rtl/perm_field_unit_chk.sv
module perm_field_unit_chk #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LEN_W = POS_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [POS_W-1:0]  lsb_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              err_o
);
  logic overrun;
  assign overrun = ({1'b0, {(LEN_W-POS_W){1'b0}}, lsb_i} + {1'b0, len_i}) > (LEN_W+1)'(DATA_W);

  assert_reset_R12: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !err_o && result_o == '0);

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(err_o));

  assert_revsh_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd2 |=> result_o[DATA_W-1:16] == {(DATA_W-16){result_o[15]}});

  assert_uxt_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd6 || op_i == 4'd7) |=> result_o[DATA_W-1:16] == '0);

  assert_overrun_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[3:2] == 2'b10 && overrun |=> err_o && result_o == $past(dst_i));

  assert_no_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[3:2] != 2'b10 |=> !err_o);

  assert_undef_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[3:2] == 2'b11 |=> result_o == '0);

  assert_src_unused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd8 && !overrun |=> (result_o & ~$past(dst_i)) == '0);
endmodule

bind perm_field_unit perm_field_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .src_i   (src_i),
  .dst_i   (dst_i),
  .lsb_i   (lsb_i),
  .len_i   (len_i),
  .valid_o (valid_o),
  .result_o(result_o),
  .err_o   (err_o)
);

// File: tb/perm_field_unit_bench.sv
`timescale 1ns/1ps
module perm_field_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] src = '0, dst = '0;
  logic [4:0]  lsb = '0;
  logic [5:0]  len = '0;
  logic        valid_q, err_q;
  logic [31:0] res_q;

  int n_chk = 0, n_fail = 0;
  logic        exp_v = 1'b0, exp_e = 1'b0;
  logic [31:0] exp_r = '0;

  always #2 clk = ~clk;

  perm_field_unit u_perm_field_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .src_i(src), .dst_i(dst), .lsb_i(lsb), .len_i(len),
    .valid_o(valid_q), .result_o(res_q), .err_o(err_q)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] s,
                                        input logic [31:0] d, input int l, input int w,
                                        output logic e);
    logic [31:0] r = '0;
    int hi = l + w;
    e = 1'b0;
    case (o)
      0: for (int b = 0; b < 4; b++) r[8*b +: 8] = s[8*(3-b) +: 8];
      1: r = {s[23:16], s[31:24], s[7:0], s[15:8]};
      2: begin r[15:0] = {s[7:0], s[15:8]}; for (int i = 16; i < 32; i++) r[i] = r[15]; end
      3: for (int i = 0; i < 32; i++) r[31-i] = s[i];
      4: r = 32'($signed(s[7:0]));
      5: r = 32'($signed(s[15:0]));
      6: r = {24'h0, s[7:0]};
      7: r = {16'h0, s[15:0]};
      8, 9, 10, 11: begin
        if (hi > 32) begin
          e = 1'b1;
          r = d;
        end else if (o == 8 || o == 9) begin
          r = d;
          for (int i = l; i < hi; i++) r[i] = (o == 9) ? s[i-l] : 1'b0;
        end else begin
          for (int i = 0; i < w; i++) r[i] = s[l+i];
          if (o == 10 && w > 0) for (int i = w; i < 32; i++) r[i] = s[hi-1];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (valid_q !== exp_v || res_q !== exp_r || err_q !== exp_e) begin
      n_fail++;
      $display("FAIL %s: got v=%0b r=%08h e=%0b expected v=%0b r=%08h e=%0b",
               req, valid_q, res_q, err_q, exp_v, exp_r, exp_e);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic [31:0] s,
                      input logic [31:0] d, input int l, input int w, input string req);
    logic e;
    logic [31:0] r;
    @(negedge clk);
    valid = v; op = o; src = s; dst = d; lsb = 5'(l); len = 6'(w);
    r = model(o, s, d, l, w, e);
    exp_v = v;
    if (v) begin exp_r = r; exp_e = e; end
    @(posedge clk); #1;
    check(req);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R12 reset");
    @(negedge clk) rst_n = 1'b1;

    step(1, 0, 32'h11223344, 0, 0, 0, "R3");
    step(1, 1, 32'h11223344, 0, 0, 0, "R4");
    step(1, 2, 32'h000080FF, 0, 0, 0, "R5");
    step(1, 2, 32'h12340056, 0, 0, 0, "R5");
    step(1, 3, 32'h00000001, 0, 0, 0, "R6");
    step(1, 3, 32'hF0000003, 0, 0, 0, "R6");
    step(1, 4, 32'h00000080, 0, 0, 0, "R7 sxt byte");
    step(1, 5, 32'h00008001, 0, 0, 0, "R7 sxt half");
    step(1, 6, 32'hFFFFFF80, 0, 0, 0, "R7 uxt byte");
    step(1, 7, 32'hFFFF8001, 0, 0, 0, "R7 uxt half");
    step(1, 8, 32'h0, 32'hFFFFFFFF, 4, 8, "R8");
    step(1, 8, 32'h0, 32'hA5A5A5A5, 31, 0, "R8 empty");
    step(1, 9, 32'h000000AB, 32'h0, 28, 4, "R9 top edge");
    step(1, 9, 32'hDEADBEEF, 32'h12345678, 0, 32, "R9 full");
    step(1, 10, 32'h00000F00, 0, 8, 4, "R10 signed");
    step(1, 11, 32'h00000F00, 0, 8, 4, "R10 unsigned");
    step(1, 10, 32'h80000000, 0, 31, 1, "R10 signed top bit");
    step(1, 11, 32'hFFFFFFFF, 0, 3, 0, "R10 empty");
    step(1, 9, 32'hFFFFFFFF, 32'hCAFEF00D, 20, 13, "R11 overrun");
    step(1, 11, 32'hFFFFFFFF, 32'h0BADCAFE, 0, 33, "R11 long");
    step(1, 0, 32'h01020304, 0, 31, 63, "R11 no err on reorder");
    step(1, 13, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 8, "R13");
    step(1, 3, 32'h12345678, 0, 0, 0, "R1");
    step(0, 0, 32'hFFFFFFFF, 32'h1, 30, 30, "R2 hold");
    step(0, 9, 32'h0, 32'h0, 0, 4, "R2 hold");
    step(1, 7, 32'h0000FFFF, 0, 0, 0, "R1 resume");
    for (int k = 0; k < 400; k++)
      step(1'($urandom_range(0, 3) != 0), 4'($urandom), $urandom, $urandom,
           int'($urandom_range(0, 31)), int'($urandom_range(0, 34)), "R1 random");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule